// File: doc/BRIEF.md
# Programmable Step-Attenuator Thermometer Controller

This block turns an 8-bit gain control word into the control vector of a thermometer-coded RF step attenuator. The six low bits of the word hold a binary gain code in half-decibel units: code 0 requests the highest gain, and each count adds 0.5 dB of attenuation. Codes above 40 give the same result as code 40, the 20 dB floor. The two high bits choose an extra "fast attack" attenuation of 2, 4, 8 or 16 dB. That extra amount is applied only while an asynchronous fast-attack pin is high. It is removed as soon as the pin returns low.

The total attenuation in half-dB units, from 0 to 72, is expanded into a 72-element thermometer vector and registered. A change of setting therefore only switches a contiguous run of elements next to the current boundary, and the attenuator sees no intermediate glitch states. The fast-attack pin passes through a two-stage synchronizer. At a 250 MHz clock the pin reaches the output in three clocks, which is 12 ns. A low enable input parks the attenuator at full attenuation for sleep. When enable returns, the output follows the control word again.

Top module: `atten_ctrl`

## Requirements
- R1: While reset is high, and on the first clock after it, the attenuator vector is all ones (full attenuation).
- R2: With the fast-attack pin low and enable high, a gain code g in bits [5:0] with g <= 40 produces a vector in which exactly elements 0 to g-1 are set.
- R3: A gain code above 40 gives the same vector as code 40, which is elements 0 to 39 set.
- R4: While the synchronized fast-attack pin is high, the attenuation is the clamped gain code plus 4, 8, 16 or 32 half-dB units, for bits [7:6] equal to 00, 01, 10 or 11.
- R5: After the fast-attack pin falls, the vector returns to the programmed attenuation without fast attack.
- R6: A level change on the fast-attack pin, sampled at one rising edge, appears at the output on the third rising edge after it and not earlier.
- R7: The output vector is always a thermometer code: element i is set exactly when the total attenuation exceeds i, up to all 72 elements at gain code 40 plus the 16 dB step.
- R8: When enable is sampled low, the vector is all ones at the next edge and changes to the control word have no visible effect. One edge after enable is sampled high again, the vector shows the current setting.
- R9: A change of the control word with enable high shows at the output after one rising edge.
- R10: Changing bits [7:6] while fast attack is active changes the added step after one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_byte | input | 8 | Bits [7:6] select the fast-attack step, bits [5:0] hold the gain code |
| fa_pin | input | 1 | Asynchronous fast-attack request, active high |
| enable | input | 1 | High for normal operation, low for sleep at full attenuation |
| atten_therm | output | 72 | Registered thermometer vector, one element per 0.5 dB |

## Verification
Three events can land on the same clock: a fast-attack edge coming out of the synchronizer, a new control word, and an enable transition. The bench provokes each pairing deliberately. It raises the pin in the same cycle that enable falls, and requires full attenuation throughout. It re-enables while fast attack is held, and requires the programmed value plus the step at once. It writes a new control word in the cycle the pin rises, and requires the new base after one edge and the new base plus its own step after three. Every expected value is computed from the clamped code and the step table, across an exhaustive sweep of all 256 control words with the pin both low and high.

// File: rtl/atten_pkg.sv
package atten_pkg;

    localparam int GAIN_W    = 6;
    localparam int SEL_W     = 2;
    localparam int CODE_MAX  = 40;
    localparam int FA_BASE   = 4;
    localparam int FA_MAX    = FA_BASE << ((1 << SEL_W) - 1);
    localparam int THERM_N   = CODE_MAX + FA_MAX;
    localparam int UNIT_W    = $clog2(THERM_N + 1);

    typedef logic [UNIT_W-1:0] units_t;

    typedef struct packed {
        logic [SEL_W-1:0]  fa_sel;
        logic [GAIN_W-1:0] gain;
    } ctrl_t;

    // Saturate the binary gain code at the attenuation floor.
    function automatic units_t clamp_gain(input logic [GAIN_W-1:0] g);
        if (int'(g) > CODE_MAX)
            return units_t'(CODE_MAX);
        else
            return units_t'(g);
    endfunction

    // Fast-attack step in half-dB units: doubles with each select value.
    function automatic units_t fa_units(input logic [SEL_W-1:0] sel);
        return units_t'(FA_BASE << sel);
    endfunction

endpackage

// File: rtl/atten_fa_sync.sv
module atten_fa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];

    initial begin
        a_r6_stage_count: assert (STAGES >= 2);
    end
endmodule

// File: rtl/atten_sum.sv
module atten_sum
    import atten_pkg::*;
(
    input  ctrl_t  ctrl,
    input  logic   fa_active,
    output units_t total
);
    units_t base;
    units_t extra;

    always_comb begin
        base  = clamp_gain(ctrl.gain);
        extra = fa_active ? fa_units(ctrl.fa_sel) : '0;
        total = base + extra;
    end

    always_comb begin
        a_r3_floor_clamp: assert (int'(base) <= CODE_MAX);
        a_r7_total_range: assert (int'(total) <= THERM_N);
    end
endmodule

// File: rtl/atten_therm_enc.sv
module atten_therm_enc #(
    parameter int N = 72,
    parameter int W = 7
) (
    input  logic [W-1:0] units,
    output logic [N-1:0] therm
);
    for (genvar i = 0; i < N; i++) begin : g_elem
        assign therm[i] = (int'(units) > i);
    end
endmodule

// File: rtl/atten_ctrl.sv
module atten_ctrl
    import atten_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         ctrl_byte,
    input  logic               fa_pin,
    input  logic               enable,
    output logic [THERM_N-1:0] atten_therm
);
    localparam logic [THERM_N-1:0] LSB_ONE = {{(THERM_N-1){1'b0}}, 1'b1};

    ctrl_t               ctrl;
    logic                fa_s;
    units_t              total;
    logic [THERM_N-1:0]  therm_next;
    logic [THERM_N-1:0]  therm_q;

    assign ctrl = ctrl_t'(ctrl_byte);

    atten_fa_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (fa_pin),
        .sync_out (fa_s)
    );

    atten_sum u_sum (
        .ctrl      (ctrl),
        .fa_active (fa_s),
        .total     (total)
    );

    atten_therm_enc #(.N(THERM_N), .W(UNIT_W)) u_enc (
        .units (total),
        .therm (therm_next)
    );

    // Sleep and reset both park the attenuator at full attenuation.
    always_ff @(posedge clk) begin
        if (rst || !enable)
            therm_q <= '1;
        else
            therm_q <= therm_next;
    end

    assign atten_therm = therm_q;

    a_r1_reset_full: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (&therm_q));

    a_r7_contiguous: assert property (@(posedge clk) disable iff (rst)
        ((therm_q & (therm_q + LSB_ONE)) == '0));

    a_r8_sleep_full: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (&therm_q));

    a_r4_fa_no_less: assert property (@(posedge clk) disable iff (rst)
        ($rose(fa_s) && enable && $past(enable) && $stable(ctrl_byte))
        |=> ($countones(therm_q) >= $past($countones(therm_q))));

    a_r5_release_no_more: assert property (@(posedge clk) disable iff (rst)
        ($fell(fa_s) && enable && $stable(ctrl_byte))
        |=> ($countones(therm_q) <= $past($countones(therm_q))));
endmodule

// File: tb/atten_ctrl_test.sv
module atten_ctrl_test;
    localparam int N = 72;

    logic         clk = 1'b0;
    logic         rst;
    logic [7:0]   ctrl_byte;
    logic         fa_pin;
    logic         enable;
    logic [N-1:0] atten_therm;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    atten_ctrl uut (
        .clk         (clk),
        .rst         (rst),
        .ctrl_byte   (ctrl_byte),
        .fa_pin      (fa_pin),
        .enable      (enable),
        .atten_therm (atten_therm)
    );

    function automatic int base_of(input logic [7:0] b);
        int g = int'(b[5:0]);
        return (g > 40) ? 40 : g;
    endfunction

    function automatic int step_of(input logic [7:0] b);
        case (b[7:6])
            2'b00:   return 4;
            2'b01:   return 8;
            2'b10:   return 16;
            default: return 32;
        endcase
    endfunction

    function automatic logic [N-1:0] vec(input int u);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = (i < u);
        return v;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic [N-1:0] exp, input string tag);
        tests++;
        if (atten_therm !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, atten_therm, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; enable = 1'b1; ctrl_byte = 8'h00; fa_pin = 1'b0;
        tick(3);
        check({N{1'b1}}, "R1 during reset");
        rst = 1'b0;
        tick(1);
        check(vec(0), "R2 code 0 after reset");

        // Exhaustive sweep of every control word, fast attack low then high.
        for (int b = 0; b < 256; b++) begin
            logic [7:0] w = 8'(b);
            ctrl_byte = w; fa_pin = 1'b0;
            tick(3);
            check(vec(base_of(w)), (int'(w[5:0]) > 40) ? "R3 clamp" : "R2 base");
            fa_pin = 1'b1;
            tick(2);
            check(vec(base_of(w)), "R6 rise not early");
            tick(1);
            check(vec(base_of(w) + step_of(w)),
                  (base_of(w) + step_of(w) == N) ? "R7 full span" : "R4 step added");
            fa_pin = 1'b0;
            tick(2);
            check(vec(base_of(w) + step_of(w)), "R6 fall not early");
            tick(1);
            check(vec(base_of(w)), "R5 release");
        end

        // One-edge update of the control word.
        ctrl_byte = 8'h05; tick(1); check(vec(5), "R9 code 5");
        ctrl_byte = 8'h28; tick(1); check(vec(40), "R9 code 40");
        ctrl_byte = 8'h29; tick(1); check(vec(40), "R3 code 41");
        ctrl_byte = 8'h3F; tick(1); check(vec(40), "R3 code 63");

        // Step select change while fast attack is held.
        ctrl_byte = 8'h0A; fa_pin = 1'b1; tick(3);
        check(vec(10 + 4), "R10 sel 00");
        ctrl_byte = 8'hCA; tick(1); check(vec(10 + 32), "R10 sel 11");
        ctrl_byte = 8'h4A; tick(1); check(vec(10 + 8), "R10 sel 01");
        fa_pin = 1'b0; tick(3); check(vec(10), "R5 after sel change");

        // Sleep, with control-word changes ignored.
        enable = 1'b0; tick(1); check({N{1'b1}}, "R8 sleep");
        ctrl_byte = 8'h02; tick(2); check({N{1'b1}}, "R8 write ignored");
        enable = 1'b1; tick(1); check(vec(2), "R8 wake");

        // Fast-attack rise in the same cycle that enable falls.
        ctrl_byte = 8'h86; fa_pin = 1'b1; enable = 1'b0;
        tick(3); check({N{1'b1}}, "R8 sleep beats fast attack");
        enable = 1'b1; tick(1); check(vec(6 + 16), "R8 wake with fast attack");
        fa_pin = 1'b0; tick(3); check(vec(6), "R5 after wake");

        // New control word in the cycle the pin rises.
        ctrl_byte = 8'h4C; fa_pin = 1'b1;
        tick(1); check(vec(12), "R9 new word before sync");
        tick(2); check(vec(12 + 8), "R4 new word plus step");
        fa_pin = 1'b0; tick(3);

        // Reset in mid-run.
        rst = 1'b1; tick(1); check({N{1'b1}}, "R1 mid-run reset");
        rst = 1'b0; tick(1); check(vec(12), "R2 after mid-run reset");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule